// File: doc/BRIEF.md
# Remote Terminal Command Screen

This block sits behind the word decoder of a serial avionics remote terminal. Each valid command word it is handed is classified in one clock. It decides whether the word is addressed to this terminal or is an enabled broadcast. It also decides whether the command is illegal, whether a data word goes with it, and in which direction that data moves. It builds the status word that the terminal would send back. The timing of data movement is left to the surrounding logic.

Strap pins carry the terminal's own address, an odd-parity bit over that address, and one broadcast enable per bus. These are sampled while reset is held and are kept for as long as the terminal runs. A subsystem status latch feeds in several live qualifiers. The subsystem can use them to force any command illegal, to accept reserved mode codes as legal, and to set individual status bits. When a reserved code is accepted, the data usage is taken from the top bit of its mode code and the direction from its T/R bit.

Command word layout: bits 15..11 target address, bit 10 T/R (1 = terminal transmits), bits 9..5 subaddress (0 or 31 = mode command), bits 4..0 word count or mode code.

Top module: `rt_cmd_screen`

## Requirements
- R1: While `rst_n` is low, and for two clocks after it rises, every result output is 0. The address, parity and broadcast enable straps are captured during that window, and later changes on the straps have no effect.
- R2: A command presented with `cmd_valid` high yields `res_valid` high for exactly one cycle, on the next clock edge. Without `cmd_valid`, `res_valid` stays low.
- R3: A command whose target address equals the stored address is accepted. A command to any other non-broadcast address gives `res_accept`=0, and then `res_illegal`, `res_has_data` and `res_data_tx` are all 0 and `res_status` keeps its previous value.
- R4: Target address 31 is a broadcast. It is accepted only when the stored enable for the bus it arrived on (`cmd_bus`) is 1. An accepted broadcast sets status bit 4.
- R5: If the XOR of the 5 stored address bits and the stored parity bit is 0, so that odd parity fails, every command is ignored.
- R6: `ss_illegal_n` low makes any accepted command illegal. An illegal command has `res_has_data`=0 and status bit 10 (message error) set.
- R7: A non-mode command carries data, and the terminal transmits it when T/R=1. For defined mode codes the required T/R is 0 for codes 17, 20 and 21 and 1 for all other codes. A wrong T/R makes the command illegal. Codes 16 to 21 carry one data word, and codes 0 to 8 carry none.
- R8: Mode codes 9 to 15 and 22 to 31 are reserved. With `ss_rsvd_reject` high they are illegal. With it low they are legal, carry data only when mode code bit 4 is 1, and take their direction from T/R.
- R9: An accepted broadcast that would make the terminal transmit is illegal. This covers a non-mode command with T/R=1, mode codes 0, 2, 16, 18 and 19, and a legal reserved code with bit 4 set and T/R=1.
- R10: The status word holds the stored address in bits 15..11, message error in bit 10, the inverse of `ss_srq_n` in bit 8, `ss_resv` in bits 7..5, broadcast received in bit 4, and the inverse of `ss_err_n` in bit 2. Bits 9, 3 and 0 are 0.
- R11: Status bit 1 is set only when `ss_dba_n` is low and the command is a legal mode code 0 (dynamic bus control).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 16 | Received command word |
| cmd_bus | input | BUS_W | Bus the command arrived on |
| strap_addr | input | 5 | Terminal address, captured in reset |
| strap_addr_par | input | 1 | Odd parity bit for the address, captured in reset |
| strap_bc_en | input | N_BUS | Per-bus broadcast enables, captured in reset |
| ss_illegal_n | input | 1 | Low: force command illegal |
| ss_rsvd_reject | input | 1 | High: reserved mode codes are illegal |
| ss_err_n | input | 1 | Low: subsystem flag |
| ss_srq_n | input | 1 | Low: service request |
| ss_dba_n | input | 1 | Low: accept dynamic bus control |
| ss_resv | input | 3 | Reserved status bit values |
| res_valid | output | 1 | Classification result valid |
| res_accept | output | 1 | Command addressed to this terminal |
| res_illegal | output | 1 | Command judged illegal |
| res_has_data | output | 1 | Data words go with the command |
| res_data_tx | output | 1 | Terminal transmits the data |
| res_status | output | 16 | Status word to reply with |

## Verification
The hardest cases to reach are the failing address parity and the per-bus broadcast enables. Both are fixed by straps that are only sampled during reset, so the bench runs extra reset cycles with other strap values. After one of those resets it changes the straps again and shows that acceptance still follows the captured values. The reserved-code cases need the subsystem qualifiers set in the same cycle as the command. So each table row carries its own `ss_illegal_n` and `ss_rsvd_reject` values next to the command word.

// File: rtl/rt_cmd_pkg.sv
package rt_cmd_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 5;
  localparam int SA_W   = 5;
  localparam int MC_W   = 5;
  localparam int TR_POS = MC_W + SA_W;
  localparam int ADDR_LO = TR_POS + 1;
  localparam logic [ADDR_W-1:0] BCAST_ADDR = '1;

  typedef struct packed {
    logic rsvd;     // reserved code
    logic need_tr;  // required T/R value
    logic data;     // one data word
    logic bc_ok;    // allowed as broadcast
  } mc_info_t;

  function automatic mc_info_t mc_lookup(input logic [MC_W-1:0] mc);
    mc_info_t r;
    r = '{rsvd: 1'b0, need_tr: 1'b1, data: 1'b0, bc_ok: 1'b1};
    case (mc)
      5'd0, 5'd2:               r.bc_ok = 1'b0;
      5'd1, 5'd3, 5'd4, 5'd5,
      5'd6, 5'd7, 5'd8:         r.bc_ok = 1'b1;
      5'd16, 5'd18, 5'd19:      begin r.data = 1'b1; r.bc_ok = 1'b0; end
      5'd17, 5'd20, 5'd21:      begin r.data = 1'b1; r.need_tr = 1'b0; end
      default:                  r.rsvd = 1'b1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rt_strap_cfg.sv
module rt_strap_cfg import rt_cmd_pkg::*; #(
  parameter int N_BUS       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic              strap_addr_par,
  input  logic [N_BUS-1:0]  strap_bc_en,
  output logic              rst_sync_n,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic              cfg_par,
  output logic [N_BUS-1:0]  cfg_bc_en
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   cap_en;

  always_comb sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;

  assign rst_sync_n = sync_q[SYNC_STAGES-1];
  assign cap_en     = ~rst_sync_n;

  always_ff @(posedge clk)
    if (cap_en) begin
      cfg_addr  <= strap_addr;
      cfg_par   <= strap_addr_par;
      cfg_bc_en <= strap_bc_en;
    end
endmodule

// File: rtl/rt_cmd_decode.sv
module rt_cmd_decode import rt_cmd_pkg::*; #(
  parameter int N_BUS = 2,
  parameter int BUS_W = 1
) (
  input  logic [WORD_W-1:0] cw,
  input  logic [BUS_W-1:0]  bus,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              own_par,
  input  logic [N_BUS-1:0]  bc_en,
  input  logic              ss_illegal_n,
  input  logic              ss_rsvd_reject,
  input  logic              ss_dba_n,
  output logic              accept,
  output logic              illegal,
  output logic              has_data,
  output logic              data_tx,
  output logic              bcast,
  output logic              dba_set
);
  logic [ADDR_W-1:0] tgt;
  logic [SA_W-1:0]   sa;
  logic [MC_W-1:0]   mc;
  logic              tr, par_ok, en_sel, is_own, is_mode;
  logic              nat_data, fmt_bad, bc_bad;
  mc_info_t          info;

  assign tgt  = cw[WORD_W-1:ADDR_LO];
  assign tr   = cw[TR_POS];
  assign sa   = cw[TR_POS-1:MC_W];
  assign mc   = cw[MC_W-1:0];
  assign info = mc_lookup(mc);

  always_comb begin
    en_sel = 1'b0;
    for (int i = 0; i < N_BUS; i++)
      if (bus == BUS_W'(i)) en_sel = bc_en[i];
  end

  assign par_ok  = ^{own_addr, own_par};
  assign bcast   = (tgt == BCAST_ADDR) & en_sel;
  assign is_own  = (tgt == own_addr) & (tgt != BCAST_ADDR);
  assign accept  = par_ok & (bcast | is_own);
  assign is_mode = (sa == '0) | (sa == '1);

  always_comb begin
    if (!is_mode) begin
      nat_data = 1'b1;
      fmt_bad  = 1'b0;
      bc_bad   = bcast & tr;
    end else if (info.rsvd) begin
      nat_data = mc[MC_W-1];
      fmt_bad  = ss_rsvd_reject;
      bc_bad   = bcast & mc[MC_W-1] & tr;
    end else begin
      nat_data = info.data;
      fmt_bad  = (tr != info.need_tr);
      bc_bad   = bcast & ~info.bc_ok;
    end
  end

  assign illegal  = accept & (~ss_illegal_n | fmt_bad | bc_bad);
  assign has_data = accept & ~illegal & nat_data;
  assign data_tx  = has_data & tr;
  assign dba_set  = accept & ~illegal & is_mode & ~info.rsvd & (mc == '0) & ~ss_dba_n;
endmodule

// File: rtl/rt_status_build.sv
module rt_status_build import rt_cmd_pkg::*; (
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              msg_err,
  input  logic              bcast,
  input  logic              dba_set,
  input  logic              ss_err_n,
  input  logic              ss_srq_n,
  input  logic [2:0]        ss_resv,
  output logic [WORD_W-1:0] status
);
  always_comb begin
    status                     = '0;
    status[WORD_W-1:ADDR_LO]   = own_addr;
    status[10]                 = msg_err;
    status[8]                  = ~ss_srq_n;
    status[7:5]                = ss_resv;
    status[4]                  = bcast;
    status[2]                  = ~ss_err_n;
    status[1]                  = dba_set;
  end
endmodule

// File: rtl/rt_cmd_screen.sv
module rt_cmd_screen import rt_cmd_pkg::*; #(
  parameter int N_BUS       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int BUS_W      = (N_BUS > 1) ? $clog2(N_BUS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic [BUS_W-1:0]  cmd_bus,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic              strap_addr_par,
  input  logic [N_BUS-1:0]  strap_bc_en,
  input  logic              ss_illegal_n,
  input  logic              ss_rsvd_reject,
  input  logic              ss_err_n,
  input  logic              ss_srq_n,
  input  logic              ss_dba_n,
  input  logic [2:0]        ss_resv,
  output logic              res_valid,
  output logic              res_accept,
  output logic              res_illegal,
  output logic              res_has_data,
  output logic              res_data_tx,
  output logic [WORD_W-1:0] res_status
);
  logic              rst_sync_n;
  logic [ADDR_W-1:0] cfg_addr;
  logic              cfg_par;
  logic [N_BUS-1:0]  cfg_bc_en;
  logic              d_accept, d_illegal, d_data, d_tx, d_bcast, d_dba;
  logic [WORD_W-1:0] built_status;
  logic              valid_d, accept_d, illegal_d, data_d, tx_d;
  logic [WORD_W-1:0] status_d;

  rt_strap_cfg #(.N_BUS(N_BUS), .SYNC_STAGES(SYNC_STAGES)) u_cfg (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr),
    .strap_addr_par(strap_addr_par), .strap_bc_en(strap_bc_en),
    .rst_sync_n(rst_sync_n), .cfg_addr(cfg_addr), .cfg_par(cfg_par),
    .cfg_bc_en(cfg_bc_en)
  );

  rt_cmd_decode #(.N_BUS(N_BUS), .BUS_W(BUS_W)) u_dec (
    .cw(cmd_word), .bus(cmd_bus), .own_addr(cfg_addr), .own_par(cfg_par),
    .bc_en(cfg_bc_en), .ss_illegal_n(ss_illegal_n),
    .ss_rsvd_reject(ss_rsvd_reject), .ss_dba_n(ss_dba_n),
    .accept(d_accept), .illegal(d_illegal), .has_data(d_data),
    .data_tx(d_tx), .bcast(d_bcast), .dba_set(d_dba)
  );

  rt_status_build u_sts (
    .own_addr(cfg_addr), .msg_err(d_illegal), .bcast(d_bcast),
    .dba_set(d_dba), .ss_err_n(ss_err_n), .ss_srq_n(ss_srq_n),
    .ss_resv(ss_resv), .status(built_status)
  );

  always_comb begin
    valid_d   = cmd_valid;
    accept_d  = cmd_valid & d_accept;
    illegal_d = cmd_valid & d_illegal;
    data_d    = cmd_valid & d_data;
    tx_d      = cmd_valid & d_tx;
    status_d  = res_status;
    if (cmd_valid && d_accept) status_d = built_status;
  end

  always_ff @(posedge clk or negedge rst_sync_n)
    if (!rst_sync_n) begin
      res_valid    <= 1'b0;
      res_accept   <= 1'b0;
      res_illegal  <= 1'b0;
      res_has_data <= 1'b0;
      res_data_tx  <= 1'b0;
      res_status   <= '0;
    end else begin
      res_valid    <= valid_d;
      res_accept   <= accept_d;
      res_illegal  <= illegal_d;
      res_has_data <= data_d;
      res_data_tx  <= tx_d;
      res_status   <= status_d;
    end
endmodule

// File: rtl/rt_cmd_screen_chk.sv
module rt_cmd_screen_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        cmd_valid,
  input logic        ss_illegal_n,
  input logic        res_valid,
  input logic        res_accept,
  input logic        res_illegal,
  input logic        res_has_data,
  input logic        res_data_tx,
  input logic [15:0] res_status
);
  a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_valid |=> res_valid);
  a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cmd_valid |=> !res_valid);
  a_r2_accept_needs_valid: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !res_valid |-> !res_accept);
  a_r3_ignored_outputs_low: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !res_accept |-> !res_illegal && !res_has_data && !res_data_tx);
  a_r3_ignored_status_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_valid && !res_accept |-> $stable(res_status));
  a_r6_forced_illegal: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_valid && res_accept && !$past(ss_illegal_n) |-> res_illegal);
  a_r6_illegal_no_data: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_illegal |-> !res_has_data);
  a_r7_tx_needs_data: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_data_tx |-> res_has_data);
  a_r10_msg_err_bit: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_valid && res_accept |-> res_status[10] == res_illegal);
  a_r11_dba_legal_only: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_valid && res_accept && res_status[1] |-> !res_illegal);
endmodule

bind rt_cmd_screen rt_cmd_screen_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .cmd_valid(cmd_valid),
  .ss_illegal_n(ss_illegal_n), .res_valid(res_valid), .res_accept(res_accept),
  .res_illegal(res_illegal), .res_has_data(res_has_data),
  .res_data_tx(res_data_tx), .res_status(res_status)
);

// File: tb/sim_rt_cmd_screen.sv
`timescale 1ns/1ps
module sim_rt_cmd_screen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [15:0] cmd_word;
  logic [0:0]  cmd_bus;
  logic [4:0]  strap_addr;
  logic        strap_addr_par;
  logic [1:0]  strap_bc_en;
  logic        ss_illegal_n, ss_rsvd_reject, ss_err_n, ss_srq_n, ss_dba_n;
  logic [2:0]  ss_resv;
  logic        res_valid, res_accept, res_illegal, res_has_data, res_data_tx;
  logic [15:0] res_status;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rt_cmd_screen u0 (.*);

  typedef struct packed {
    logic [15:0] cw;
    logic        bus;
    logic        ill_n;
    logic        rej;
    logic [3:0]  exp;   // accept, illegal, has_data, data_tx
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{ {5'd6, 1'b0, 5'd1,  5'd3 }, 1'b0, 1'b1, 1'b1, 4'b1010 }, // R3 R7 own receive
    '{ {5'd6, 1'b1, 5'd2,  5'd0 }, 1'b0, 1'b1, 1'b1, 4'b1011 }, // R7 own transmit
    '{ {5'd7, 1'b0, 5'd1,  5'd3 }, 1'b0, 1'b1, 1'b1, 4'b0000 }, // R3 other address
    '{ {5'd31,1'b0, 5'd1,  5'd4 }, 1'b0, 1'b1, 1'b1, 4'b1010 }, // R4 bcast bus0
    '{ {5'd31,1'b0, 5'd1,  5'd4 }, 1'b1, 1'b1, 1'b1, 4'b0000 }, // R4 bcast bus1 off
    '{ {5'd31,1'b1, 5'd1,  5'd4 }, 1'b0, 1'b1, 1'b1, 4'b1100 }, // R9 bcast transmit
    '{ {5'd6, 1'b1, 5'd0,  5'd1 }, 1'b0, 1'b1, 1'b1, 4'b1000 }, // R7 mode 1 ok
    '{ {5'd6, 1'b0, 5'd31, 5'd1 }, 1'b0, 1'b1, 1'b1, 4'b1100 }, // R7 mode 1 bad T/R
    '{ {5'd6, 1'b0, 5'd0,  5'd17}, 1'b0, 1'b1, 1'b1, 4'b1010 }, // R7 mode 17
    '{ {5'd6, 1'b1, 5'd31, 5'd16}, 1'b0, 1'b1, 1'b1, 4'b1011 }, // R7 mode 16
    '{ {5'd6, 1'b1, 5'd0,  5'd9 }, 1'b0, 1'b1, 1'b1, 4'b1100 }, // R8 rsvd rejected
    '{ {5'd6, 1'b1, 5'd0,  5'd9 }, 1'b0, 1'b1, 1'b0, 4'b1000 }, // R8 rsvd legal no data
    '{ {5'd6, 1'b0, 5'd0,  5'd25}, 1'b0, 1'b1, 1'b0, 4'b1010 }, // R8 rsvd legal rx data
    '{ {5'd6, 1'b1, 5'd31, 5'd30}, 1'b0, 1'b1, 1'b0, 4'b1011 }, // R8 rsvd legal tx data
    '{ {5'd6, 1'b0, 5'd1,  5'd3 }, 1'b0, 1'b0, 1'b1, 4'b1100 }, // R6 forced illegal
    '{ {5'd31,1'b1, 5'd0,  5'd2 }, 1'b0, 1'b1, 1'b1, 4'b1100 }, // R9 bcast mode 2
    '{ {5'd31,1'b1, 5'd0,  5'd1 }, 1'b0, 1'b1, 1'b1, 4'b1000 }, // R9 bcast mode 1 ok
    '{ {5'd31,1'b1, 5'd0,  5'd28}, 1'b0, 1'b1, 1'b0, 4'b1100 }, // R9 bcast rsvd tx
    '{ {5'd31,1'b0, 5'd0,  5'd20}, 1'b0, 1'b1, 1'b1, 4'b1010 }, // R7 bcast mode 20
    '{ {5'd6, 1'b0, 5'd0,  5'd22}, 1'b0, 1'b1, 1'b1, 4'b1100 }  // R8 rsvd 22 rejected
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [4:0] a, input logic p, input logic [1:0] en);
    @(negedge clk);
    rst_n = 1'b0; strap_addr = a; strap_addr_par = p; strap_bc_en = en;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] cw, input logic bus);
    cmd_word = cw; cmd_bus = bus; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic chk_res(input string tag, input logic [3:0] exp);
    check(tag, {res_accept, res_illegal, res_has_data, res_data_tx}, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp_st;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_word = '0; cmd_bus = '0;
    strap_addr = 5'd6; strap_addr_par = 1'b1; strap_bc_en = 2'b01;
    ss_illegal_n = 1'b1; ss_rsvd_reject = 1'b1; ss_err_n = 1'b1;
    ss_srq_n = 1'b1; ss_dba_n = 1'b1; ss_resv = 3'b000;

    // R1: outputs held at zero during reset, and for two clocks after release
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {res_valid, res_accept, res_illegal, res_has_data, res_data_tx, res_status}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sync release", {res_valid, res_status}, '0);
    repeat (2) @(negedge clk);

    // table walk
    exp_st = '0;
    for (int i = 0; i < NV; i++) begin
      ss_illegal_n = VEC[i].ill_n; ss_rsvd_reject = VEC[i].rej;
      send(VEC[i].cw, VEC[i].bus);
      check($sformatf("R2 valid row %0d", i), res_valid, 1'b1);
      chk_res($sformatf("R3-table row %0d", i), VEC[i].exp);
      if (VEC[i].exp[3])
        exp_st = {5'd6, VEC[i].exp[2], 5'b0, VEC[i].cw[15:11] == 5'd31, 4'b0};
      check($sformatf("R10 status row %0d", i), res_status, exp_st);
    end
    ss_illegal_n = 1'b1; ss_rsvd_reject = 1'b1;

    // R2: single-cycle result
    @(negedge clk);
    check("R2 no cmd no valid", res_valid, 1'b0);

    // R10: status field placement
    ss_srq_n = 1'b0; ss_err_n = 1'b0; ss_resv = 3'b101;
    send({5'd6, 1'b0, 5'd1, 5'd3}, 1'b0);
    check("R10 status layout", res_status, 16'h31A4);
    ss_srq_n = 1'b1; ss_err_n = 1'b1; ss_resv = 3'b000;

    // R11: dynamic bus acceptance
    ss_dba_n = 1'b0;
    send({5'd6, 1'b1, 5'd0, 5'd0}, 1'b0);
    check("R11 dba on mode 0", res_status[1], 1'b1);
    send({5'd6, 1'b1, 5'd0, 5'd1}, 1'b0);
    check("R11 dba not on mode 1", res_status[1], 1'b0);
    ss_illegal_n = 1'b0;
    send({5'd6, 1'b1, 5'd0, 5'd0}, 1'b0);
    check("R11 dba not on illegal", res_status[1:0], 2'b00);
    ss_illegal_n = 1'b1; ss_dba_n = 1'b1;

    // R3: ignored command leaves status untouched
    exp_st = res_status;
    send({5'd9, 1'b0, 5'd1, 5'd3}, 1'b0);
    check("R3 ignored status", res_status, exp_st);

    // R5: bad parity ignores own address
    do_reset(5'd6, 1'b0, 2'b11);
    send({5'd6, 1'b0, 5'd1, 5'd3}, 1'b0);
    chk_res("R5 parity fail own", 4'b0000);
    send({5'd31, 1'b0, 5'd1, 5'd3}, 1'b1);
    chk_res("R5 parity fail bcast", 4'b0000);
    check("R5 status untouched", res_status, 16'h0000);

    // R4 / R1: bus 1 only enabled, straps changed after reset
    do_reset(5'd3, 1'b1, 2'b10);
    strap_addr = 5'd4; strap_addr_par = 1'b0; strap_bc_en = 2'b01;
    @(negedge clk);
    send({5'd31, 1'b0, 5'd2, 5'd1}, 1'b1);
    chk_res("R4 bcast bus1 enabled", 4'b1010);
    check("R4 bcast status bit", res_status, {5'd3, 6'b0, 1'b1, 4'b0});
    send({5'd31, 1'b0, 5'd2, 5'd1}, 1'b0);
    chk_res("R4 bcast bus0 disabled", 4'b0000);
    send({5'd4, 1'b0, 5'd2, 5'd1}, 1'b0);
    chk_res("R1 late strap address ignored", 4'b0000);
    send({5'd3, 1'b0, 5'd2, 5'd1}, 1'b0);
    chk_res("R1 captured address kept", 4'b1010);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule